// File: doc/BRIEF.md
# Vector-by-Scalar Lane Multiplier

This unit multiplies every lane of a vector operand by a single scalar element. The scalar is read from a bank of sixteen 64-bit entries that sits inside the block and has its own write port. An operation names a bank entry and an element position within that entry. It also picks an element size (16 or 32 bits), a signedness and the vector width (64 or 128 bits). Two further controls are optional: saturating doubling, and long mode, in which each product keeps its full double width.

The scalar can come only from a restricted window of the bank, and that window depends on the element size. A request outside the window produces no result. It raises an error strobe instead, which leaves the pipeline with the same timing as a normal result. The datapath has three register stages and accepts one operation every clock, so results leave in issue order at a fixed distance from the operation that produced them.

Top module: `vec_scalar_mul`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `out_err` are 0 and `out_data` is zero. Reset also clears every bank entry to zero, so an operation issued before any write yields all-zero lanes.
- R2: When `wr_en` is high, `wr_data` is stored into the entry `wr_idx` at the clock edge. An operation sampled at that same edge reads the entry's previous contents, and a later operation reads the new value.
- R3: `in_esz` encodes the element size as 2'b01 for 16 bits and 2'b10 for 32 bits; 2'b00 and 2'b11 are illegal. A 16-bit operation is legal only for `in_reg` 0..7, with any `in_elem` from 0 to 3. A 32-bit operation is legal only for `in_reg` 0..15 with `in_elem` 0 or 1. `in_reg` is 5 bits wide, so values 16..31 are always illegal.
- R4: The scalar is element `in_elem` of the 64-bit entry, that is bits [16*in_elem +: 16] for 16-bit elements and bits [32*in_elem +: 32] for 32-bit elements. The same scalar multiplies every lane.
- R5: In plain mode (`in_sat`=0, `in_long`=0), result lane i is the low element-width bits of the product of vector lane i and the scalar. If `in_quad`=1 all 128 bits are processed. If `in_quad`=0 only the low 64 bits are processed, and bits 127:64 of the result are zero.
- R6: With `in_signed`=1 both operands are read as two's complement. With `in_signed`=0 both are read as unsigned. The difference shows in the long and upper-half results.
- R7: In long mode (`in_long`=1, `in_sat`=0), the low 64 bits of `in_vec` supply the lanes. Each result lane is the full product at twice the element width, packed into 128 bits. `in_quad` has no effect in this mode.
- R8: In saturating mode (`in_sat`=1, `in_long`=0), the operands are always signed and `in_signed` has no effect. Each lane is the upper half of twice the product. If both inputs are the most negative value, the lane is clamped to the largest positive value (16'h7FFF or 32'h7FFF_FFFF).
- R9: In saturating long mode (`in_sat`=1, `in_long`=1), each double-width lane is twice the signed product. If both inputs are the most negative value, the lane is clamped to the largest positive double-width value.
- R10: An operation sampled at clock edge E produces its outputs at the second edge after E. `out_valid` (legal case) or `out_err` (illegal case) is high for exactly one cycle.
- R11: A new operation is accepted on every clock. Back-to-back operations produce results on consecutive cycles, in issue order.
- R12: An illegal operation raises `out_err` with `out_valid` low and `out_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bank write enable |
| wr_idx | input | 4 | Bank entry to write |
| wr_data | input | 64 | Bank write data |
| in_valid | input | 1 | Operation strobe |
| in_vec | input | 128 | Vector operand |
| in_reg | input | 5 | Bank entry holding the scalar |
| in_elem | input | 2 | Element position of the scalar in that entry |
| in_esz | input | 2 | Element size code (01 = 16, 10 = 32) |
| in_signed | input | 1 | Operands are two's complement |
| in_sat | input | 1 | Saturating doubling mode |
| in_long | input | 1 | Double-width result lanes |
| in_quad | input | 1 | 128-bit vector (else 64-bit) |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Illegal-select strobe |
| out_data | output | 128 | Product vector |

## Verification
The vectors are chosen to contain the most negative value, the most positive value, all-ones and small numbers in different lanes. One scalar pattern is therefore enough to separate signed from unsigned extension, low-half from long results, and a correct saturating clamp from simple wrap-around. Operations that differ only in element position, vector width or the signedness bit show whether the scalar is picked correctly and whether a control that should be ignored really is. Selects just inside and just outside each legal window, together with both reserved size codes, check the error path. A write to an entry in the same cycle as a read of that entry, followed by three operations on consecutive cycles, checks the read timing and the in-order flow of the pipeline.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    typedef enum logic [1:0] {
        ESZ_8  = 2'b00,
        ESZ_16 = 2'b01,
        ESZ_32 = 2'b10,
        ESZ_64 = 2'b11
    } esize_e;

    typedef struct packed {
        esize_e esz;
        logic   sgn;
        logic   sat;
        logic   lng;
        logic   quad;
    } op_ctrl_t;

    // Upper half of 2*p for a 16x16 signed product p; only min*min overflows.
    function automatic logic [15:0] dbl_hi16(input logic [31:0] p);
        return (p == 32'h4000_0000) ? 16'h7FFF : p[30:15];
    endfunction

    function automatic logic [31:0] dbl_full32(input logic [31:0] p);
        return (p == 32'h4000_0000) ? 32'h7FFF_FFFF : {p[30:0], 1'b0};
    endfunction

    function automatic logic [31:0] dbl_hi32(input logic [63:0] p);
        return (p == 64'h4000_0000_0000_0000) ? 32'h7FFF_FFFF : p[62:31];
    endfunction

    function automatic logic [63:0] dbl_full64(input logic [63:0] p);
        return (p == 64'h4000_0000_0000_0000) ? 64'h7FFF_FFFF_FFFF_FFFF : {p[62:0], 1'b0};
    endfunction

endpackage

// File: rtl/vsm_scalar_bank.sv
module vsm_scalar_bank
    import vsm_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int REG_W = 64,
    localparam int RI_W = $clog2(NREG),
    localparam int IX_W = RI_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RI_W-1:0]   wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [IX_W-1:0]   rd_reg,
    input  logic [1:0]        rd_el,
    input  esize_e            esz,
    output logic [15:0]       s16,
    output logic [31:0]       s32,
    output logic              legal
);
    localparam int HALF_REG = NREG / 2;

    logic [REG_W-1:0] bank [NREG];
    logic [REG_W-1:0] entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) bank[k] <= '0;
        end else if (wr_en) begin
            bank[wr_idx] <= wr_data;
        end
    end

    assign entry = bank[rd_reg[RI_W-1:0]];
    assign s16   = entry[16*rd_el +: 16];
    assign s32   = entry[32*rd_el[0] +: 32];

    always_comb begin
        case (esz)
            ESZ_16:  legal = (rd_reg < IX_W'(HALF_REG));
            ESZ_32:  legal = (rd_reg < IX_W'(NREG)) && !rd_el[1];
            default: legal = 1'b0;
        endcase
    end

    // R2: a write lands in the addressed entry at the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (bank[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/vsm_lane_mul.sv
module vsm_lane_mul #(
    parameter int VEC_W = 128,
    localparam int L16 = VEC_W / 16,
    localparam int L32 = VEC_W / 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [VEC_W-1:0]       vec,
    input  logic [15:0]            s16,
    input  logic [31:0]            s32,
    input  logic                   sgn,
    output logic [L16-1:0][31:0]   p16,
    output logic [L32-1:0][63:0]   p32
);
    genvar i;
    generate
        for (i = 0; i < L16; i++) begin : g_h
            logic signed [16:0] xa, xb;
            logic signed [33:0] pr;
            assign xa = {sgn & vec[16*i+15], vec[16*i +: 16]};
            assign xb = {sgn & s16[15], s16};
            assign pr = xa * xb;
            always_ff @(posedge clk) begin
                if (rst) p16[i] <= '0;
                else     p16[i] <= pr[31:0];
            end
        end
        for (i = 0; i < L32; i++) begin : g_w
            logic signed [32:0] xa, xb;
            logic signed [65:0] pr;
            assign xa = {sgn & vec[32*i+31], vec[32*i +: 32]};
            assign xb = {sgn & s32[31], s32};
            assign pr = xa * xb;
            always_ff @(posedge clk) begin
                if (rst) p32[i] <= '0;
                else     p32[i] <= pr[63:0];
            end
        end
    endgenerate

endmodule

// File: rtl/vsm_pack.sv
module vsm_pack
    import vsm_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int REG_W = 64,
    localparam int L16 = VEC_W / 16,
    localparam int L32 = VEC_W / 32,
    localparam int N16 = REG_W / 16,
    localparam int N32 = REG_W / 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   b_valid,
    input  logic                   b_err,
    input  op_ctrl_t               b_ctrl,
    input  logic [L16-1:0][31:0]   p16,
    input  logic [L32-1:0][63:0]   p32,
    output logic                   out_valid,
    output logic                   out_err,
    output logic [VEC_W-1:0]       out_data
);
    logic [VEC_W-1:0] res;

    always_comb begin
        res = '0;
        case (b_ctrl.esz)
            ESZ_16: begin
                if (b_ctrl.lng) begin
                    for (int i = 0; i < N16; i++)
                        res[32*i +: 32] = b_ctrl.sat ? dbl_full32(p16[i]) : p16[i];
                end else begin
                    for (int i = 0; i < L16; i++)
                        if (b_ctrl.quad || i < N16)
                            res[16*i +: 16] = b_ctrl.sat ? dbl_hi16(p16[i]) : p16[i][15:0];
                end
            end
            ESZ_32: begin
                if (b_ctrl.lng) begin
                    for (int i = 0; i < N32; i++)
                        res[64*i +: 64] = b_ctrl.sat ? dbl_full64(p32[i]) : p32[i];
                end else begin
                    for (int i = 0; i < L32; i++)
                        if (b_ctrl.quad || i < N32)
                            res[32*i +: 32] = b_ctrl.sat ? dbl_hi32(p32[i]) : p32[i][31:0];
                end
            end
            default: res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= b_valid;
            out_err   <= b_err;
            out_data  <= b_valid ? res : '0;
        end
    end

    // R12: an error strobe carries no data and no valid
    a_r12_err_blank: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (!out_valid && out_data == '0));

endmodule

// File: rtl/vec_scalar_mul.sv
module vec_scalar_mul
    import vsm_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int REG_W = 64,
    parameter int NREG  = 16,
    localparam int RI_W = $clog2(NREG),
    localparam int IX_W = RI_W + 1,
    localparam int L16  = VEC_W / 16,
    localparam int L32  = VEC_W / 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RI_W-1:0]   wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  in_vec,
    input  logic [IX_W-1:0]   in_reg,
    input  logic [1:0]        in_elem,
    input  logic [1:0]        in_esz,
    input  logic              in_signed,
    input  logic              in_sat,
    input  logic              in_long,
    input  logic              in_quad,
    output logic              out_valid,
    output logic              out_err,
    output logic [VEC_W-1:0]  out_data
);
    esize_e             esz_in;
    logic [15:0]        sc16;
    logic [31:0]        sc32;
    logic               legal;

    // stage A: operands captured
    logic               a_valid, a_err;
    op_ctrl_t           a_ctrl;
    logic [VEC_W-1:0]   a_vec;
    logic [15:0]        a_s16;
    logic [31:0]        a_s32;

    // stage B: products captured
    logic               b_valid, b_err;
    op_ctrl_t           b_ctrl;
    logic [L16-1:0][31:0] p16;
    logic [L32-1:0][63:0] p32;

    assign esz_in = esize_e'(in_esz);

    vsm_scalar_bank #(.NREG(NREG), .REG_W(REG_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_reg (in_reg),
        .rd_el  (in_elem),
        .esz    (esz_in),
        .s16    (sc16),
        .s32    (sc32),
        .legal  (legal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
            a_err   <= 1'b0;
            a_ctrl  <= '0;
            a_vec   <= '0;
            a_s16   <= '0;
            a_s32   <= '0;
        end else begin
            a_valid <= in_valid && legal;
            a_err   <= in_valid && !legal;
            a_ctrl  <= '{esz: esz_in, sgn: in_signed | in_sat, sat: in_sat,
                         lng: in_long, quad: in_quad};
            a_vec   <= in_vec;
            a_s16   <= sc16;
            a_s32   <= sc32;
        end
    end

    vsm_lane_mul #(.VEC_W(VEC_W)) u_mul (
        .clk(clk),
        .rst(rst),
        .vec(a_vec),
        .s16(a_s16),
        .s32(a_s32),
        .sgn(a_ctrl.sgn),
        .p16(p16),
        .p32(p32)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            b_valid <= 1'b0;
            b_err   <= 1'b0;
            b_ctrl  <= '0;
        end else begin
            b_valid <= a_valid;
            b_err   <= a_err;
            b_ctrl  <= a_ctrl;
        end
    end

    vsm_pack #(.VEC_W(VEC_W), .REG_W(REG_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .b_valid  (b_valid),
        .b_err    (b_err),
        .b_ctrl   (b_ctrl),
        .p16      (p16),
        .p32      (p32),
        .out_valid(out_valid),
        .out_err  (out_err),
        .out_data (out_data)
    );

    // R10: a legal operation yields a result strobe two edges after its sampling edge
    a_r10_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal) |-> ##3 (out_valid && !out_err));

    // R12: an illegal operation yields the error strobe on the same schedule
    a_r12_err_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legal) |-> ##3 (out_err && !out_valid));

endmodule

// File: tb/vec_scalar_mul_tb.sv
module vec_scalar_mul_tb;

    typedef struct packed {
        logic [4:0]   rg;
        logic [1:0]   el;
        logic [1:0]   esz;
        logic         sgn;
        logic         sat;
        logic         lng;
        logic         quad;
        logic [127:0] vec;
    } tv_t;

    localparam logic [127:0] VA = 128'h8000_7FFF_0001_FFFF_0002_FFFE_1234_0005;
    localparam logic [127:0] VB = 128'h8000_0000_7FFF_FFFF_0000_0003_FFFF_FFFE;
    localparam logic [127:0] VC = 128'h0000_0001_0000_0002_8000_0000_7FFF_FFFF;
    localparam logic [127:0] VD = 128'h0123_4567_89AB_CDEF_8000_0001_7FFF_FFFF;

    localparam int NT = 18;
    localparam tv_t TBL [NT] = '{
        '{5'd0,  2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, VA}, // R4 R5 R6 signed, quad
        '{5'd0,  2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, VA}, // R4 other element, 64-bit
        '{5'd0,  2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, VD}, // R7 signed long
        '{5'd0,  2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, VD}, // R7 unsigned long, quad ignored
        '{5'd0,  2'd3, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, VA}, // R8 clamp, signedness ignored
        '{5'd0,  2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, VD}, // R9 clamp 16
        '{5'd7,  2'd3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, VA}, // R3 highest legal 16 select
        '{5'd9,  2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, VB},
        '{5'd9,  2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, VB},
        '{5'd9,  2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, VB}, // R8 clamp 32
        '{5'd9,  2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, VC}, // R9 clamp 32
        '{5'd15, 2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, VB}, // R3 highest legal 32 select
        '{5'd15, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, VB},
        '{5'd8,  2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, VA}, // illegal: entry 8 at 16 bits
        '{5'd9,  2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, VB}, // illegal: element 2 at 32 bits
        '{5'd16, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, VB}, // illegal: entry 16
        '{5'd0,  2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, VA}, // illegal size code 00
        '{5'd0,  2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, VA}  // illegal size code 11
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_idx = '0;
    logic [63:0]  wr_data = '0;
    logic         in_valid = 1'b0;
    logic [127:0] in_vec = '0;
    logic [4:0]   in_reg = '0;
    logic [1:0]   in_elem = '0;
    logic [1:0]   in_esz = '0;
    logic         in_signed = 1'b0;
    logic         in_sat = 1'b0;
    logic         in_long = 1'b0;
    logic         in_quad = 1'b0;
    logic         out_valid, out_err;
    logic [127:0] out_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [63:0] shadow [16];

    always #2 clk = ~clk;

    vec_scalar_mul u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .in_valid(in_valid), .in_vec(in_vec), .in_reg(in_reg), .in_elem(in_elem),
        .in_esz(in_esz), .in_signed(in_signed), .in_sat(in_sat), .in_long(in_long),
        .in_quad(in_quad), .out_valid(out_valid), .out_err(out_err), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_legal(tv_t o);
        if (o.esz == 2'd1) return o.rg < 5'd8;
        if (o.esz == 2'd2) return (o.rg < 5'd16) && (o.el < 2'd2);
        return 1'b0;
    endfunction

    function automatic logic [127:0] model(tv_t o, logic [63:0] ent);
        logic [127:0] r;
        bit sg;
        r  = '0;
        sg = o.sgn | o.sat;
        if (o.esz == 2'd1) begin
            for (int i = 0; i < 8; i++) begin
                logic [15:0] a, b;
                logic signed [33:0] pa, pb, p, d;
                a  = o.vec[16*i +: 16];
                b  = ent[16*o.el +: 16];
                pa = sg ? {{18{a[15]}}, a} : {18'b0, a};
                pb = sg ? {{18{b[15]}}, b} : {18'b0, b};
                p  = pa * pb;
                d  = p <<< 1;
                if (o.lng) begin
                    if (i < 4)
                        r[32*i +: 32] = o.sat ? ((d > 34'sh7FFF_FFFF) ? 32'h7FFF_FFFF : d[31:0]) : p[31:0];
                end else if (o.quad || i < 4) begin
                    r[16*i +: 16] = o.sat ? (((d >>> 16) > 34'sd32767) ? 16'h7FFF : d[31:16]) : p[15:0];
                end
            end
        end else if (o.esz == 2'd2) begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] a, b;
                logic signed [65:0] pa, pb, p, d;
                a  = o.vec[32*i +: 32];
                b  = ent[32*o.el[0] +: 32];
                pa = sg ? {{34{a[31]}}, a} : {34'b0, a};
                pb = sg ? {{34{b[31]}}, b} : {34'b0, b};
                p  = pa * pb;
                d  = p <<< 1;
                if (o.lng) begin
                    if (i < 2)
                        r[64*i +: 64] = o.sat ? ((d > 66'sh7FFF_FFFF_FFFF_FFFF) ? 64'h7FFF_FFFF_FFFF_FFFF : d[63:0]) : p[63:0];
                end else if (o.quad || i < 2) begin
                    r[32*i +: 32] = o.sat ? (((d >>> 32) > 66'sh7FFF_FFFF) ? 32'h7FFF_FFFF : d[63:32]) : p[31:0];
                end
            end
        end
        return r;
    endfunction

    function automatic string tag_of(tv_t o);
        if (!is_legal(o)) return "R3 R12";
        if (o.sat && o.lng) return "R9";
        if (o.sat) return "R8";
        if (o.lng) return "R7 R6";
        return "R4 R5 R6";
    endfunction

    task automatic drive(tv_t o);
        in_valid  = 1'b1;
        in_vec    = o.vec;
        in_reg    = o.rg;
        in_elem   = o.el;
        in_esz    = o.esz;
        in_signed = o.sgn;
        in_sat    = o.sat;
        in_long   = o.lng;
        in_quad   = o.quad;
    endtask

    task automatic expect_out(tv_t o, logic [127:0] exp_d, string tag);
        bit lg;
        lg = is_legal(o);
        chk(out_valid == lg,  {tag, " valid"}, 128'(out_valid), 128'(lg));
        chk(out_err   == !lg, {tag, " err"},   128'(out_err),   128'(!lg));
        chk(out_data  == exp_d, {tag, " data"}, out_data, exp_d);
    endtask

    task automatic run_one(tv_t o, string tag);
        logic [127:0] e;
        e = is_legal(o) ? model(o, shadow[o.rg[3:0]]) : '0;
        @(negedge clk); drive(o);
        @(negedge clk); in_valid = 1'b0;
        repeat (2) @(negedge clk);
        expect_out(o, e, tag);
    endtask

    task automatic write_reg(int k, logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(k); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[k] = v;
    endtask

    function automatic logic [63:0] pat(int k);
        case (k)
            0:       return 64'h8000_7FFF_FFFF_0003;
            7:       return 64'h1234_0010_FFFE_8000;
            9:       return 64'h8000_0000_7FFF_FFFF;
            15:      return 64'hFFFF_FFFF_0000_0002;
            default: return 64'(k) * 64'h0001_0001_0001_0001;
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tv_t o0, o1, o2, o3;
        logic [127:0] e1, e2, e3;
        for (int k = 0; k < 16; k++) shadow[k] = '0;

        // R1: outputs quiet under reset
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_err == 1'b0, "R1 reset strobes", {126'b0, out_valid, out_err}, '0);
        chk(out_data == '0, "R1 reset data", out_data, '0);
        @(negedge clk); rst = 1'b0;

        // R1: cleared bank gives zero lanes
        o0 = '{5'd3, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, VA};
        run_one(o0, "R1 cleared bank");

        for (int k = 0; k < 16; k++) write_reg(k, pat(k));

        foreach (TBL[t]) run_one(TBL[t], tag_of(TBL[t]));

        // R2: op in the write cycle sees the old entry, the next sees the new one
        o1 = '{5'd5, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, VA};
        e1 = model(o1, shadow[5]);
        @(negedge clk);
        drive(o1); wr_en = 1'b1; wr_idx = 4'd5; wr_data = 64'h0000_FFF0_0000_0000;
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b0; shadow[5] = 64'h0000_FFF0_0000_0000;
        repeat (2) @(negedge clk);
        expect_out(o1, e1, "R2 same-cycle write");
        run_one(o1, "R2 after write");

        // R11: three operations on consecutive cycles
        o1 = TBL[0]; o2 = TBL[13]; o3 = TBL[10];
        e1 = model(o1, shadow[o1.rg[3:0]]);
        e2 = '0;
        e3 = model(o3, shadow[o3.rg[3:0]]);
        @(negedge clk); drive(o1);
        @(negedge clk); drive(o2);
        @(negedge clk); drive(o3);
        @(negedge clk); in_valid = 1'b0;
        expect_out(o1, e1, "R11 first");
        @(negedge clk); expect_out(o2, e2, "R11 second");
        @(negedge clk); expect_out(o3, e3, "R11 third");
        @(negedge clk);
        chk(out_valid == 1'b0 && out_err == 1'b0, "R10 single-cycle strobe", {126'b0, out_valid, out_err}, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule